// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the next control-memory address in a microprogrammed control unit. It holds the 7-bit control address register, whose value is the address applied to control memory, and a store for subroutine return addresses. Every cycle it takes three fields of the microinstruction being executed: a 2-bit condition selector, a 2-bit branch code and a 7-bit target address. It also takes three status bits from the datapath (the indirect flag, the accumulator sign and the accumulator-is-zero flag) and the 4-bit opcode held in the data register.

A condition multiplexer reduces the status bits to a single test bit. Small input logic turns the branch code and the test bit into a 2-bit source select and a push strobe. A four-way multiplexer then loads the address register from one of four sources: the incremented address, the target field, the top of the return store, or an address formed from the opcode. By default the return store is a single register. A parameter turns it into a last-in, first-out stack of up to eight entries.

Top module: `uaddr_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `car_addr` becomes 64 (the fetch routine) and the return store is cleared.
- R2: The test bit is chosen by `cond_sel`. 2'b00 gives constant 1, 2'b01 gives `ind_bit`, 2'b10 gives `acc_sign` and 2'b11 gives `acc_zero`.
- R3: Branch code 2'b00 (jump) loads `jump_addr` when the test bit is 1. Otherwise it loads `car_addr + 1`.
- R4: Branch code 2'b01 (call) loads `jump_addr` and pushes `car_addr + 1` into the return store when the test bit is 1. When the test bit is 0 it loads `car_addr + 1` and leaves the return store unchanged.
- R5: Branch code 2'b10 (return) loads the top of the return store, whatever the test bit.
- R6: Branch code 2'b11 (map) loads {1'b0, opcode[3:0], 2'b00}, whatever the test bit.
- R7: Incrementing from 127 wraps to 0.
- R8: With `RET_DEPTH` = 1, a return does not change the stored value, so repeated returns reach the same address. With `RET_DEPTH` > 1, calls push and returns pop in last-in, first-out order, wrapping silently.
- R9: The source select is S1 = br[1] and S0 = ~br[1]&T | br[1]&br[0], with 0 = increment, 1 = target field, 2 = return store, 3 = mapped opcode. The push strobe is ~br[1]&br[0]&T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_sel | input | 2 | Condition selector of the current microinstruction |
| br_code | input | 2 | Branch code of the current microinstruction |
| jump_addr | input | 7 | Target address field of the current microinstruction |
| ind_bit | input | 1 | Indirect flag from the data register |
| acc_sign | input | 1 | Accumulator sign bit |
| acc_zero | input | 1 | Accumulator equals zero |
| opcode | input | 4 | Opcode bits from the data register |
| car_addr | output | 7 | Control address presented to control memory |

## Verification
Two functions can fall in the same cycle. In a taken call, the address register loads the target field while the return store captures the old address plus one, and both depend on the same test bit. The bench sets up taken and not-taken calls under every condition selector. It then issues returns and compares the addresses they reach with a reference model, so a push that goes missing or is spurious shows up at `car_addr`. A call or jump made from address 127 combines the wrap with the push. The bench reaches 127 on purpose and checks both the landing address and the return address that was saved.

// File: rtl/uaddr_pkg.sv
// Package: shared encodings for the microprogram address sequencer.
// Assumes the 2-bit branch and condition fields of the microinstruction.
package uaddr_pkg;

    typedef enum logic [1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_code_e;

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_IND    = 2'b01,
        COND_SIGN   = 2'b10,
        COND_ZERO   = 2'b11
    } cond_e;

    typedef enum logic [1:0] {
        SRC_INC   = 2'b00,
        SRC_FIELD = 2'b01,
        SRC_RET   = 2'b10,
        SRC_MAP   = 2'b11
    } src_e;

endpackage

// File: rtl/uaddr_cond_mux.sv
// Module: uaddr_cond_mux
// Reduces the status inputs to one test bit, chosen by the condition field.
// Assumes the status bits are stable during the cycle in which they are used.
module uaddr_cond_mux
    import uaddr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cond_sel,
    input  logic       ind_bit,
    input  logic       acc_sign,
    input  logic       acc_zero,
    output logic       test_bit
);

    logic [3:0] cand;

    // Gather the four candidate test sources, indexed by code.
    always_comb begin
        cand          = '0;
        cand[COND_ALWAYS] = 1'b1;
        cand[COND_IND]    = ind_bit;
        cand[COND_SIGN]   = acc_sign;
        cand[COND_ZERO]   = acc_zero;
        test_bit      = cand[cond_sel];
    end

    // R2: each code routes its own status source.
    a_r2_always: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == COND_ALWAYS) |-> test_bit);
    a_r2_ind: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == COND_IND) |-> (test_bit == ind_bit));
    a_r2_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == COND_SIGN) |-> (test_bit == acc_sign));
    a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == COND_ZERO) |-> (test_bit == acc_zero));

endmodule

// File: rtl/uaddr_input_logic.sv
// Module: uaddr_input_logic
// Turns the branch code and test bit into the source select and the
// return-store push and pop strobes. Pure combinational logic.
module uaddr_input_logic
    import uaddr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] br_code,
    input  logic       test_bit,
    output logic [1:0] src_sel,
    output logic       push,
    output logic       pop
);

    // Sum-of-products select and load equations.
    always_comb begin
        src_sel[1] = br_code[1];
        src_sel[0] = (~br_code[1] & test_bit) | (br_code[1] & br_code[0]);
        push       = ~br_code[1] & br_code[0] & test_bit;
        pop        = br_code[1] & ~br_code[0];
    end

    // R9: a push only comes with a target-field load.
    a_r9_push_with_field: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (src_sel == SRC_FIELD));
    // R9: push and pop never coincide.
    a_r9_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    // R5: a return always selects the return store.
    a_r5_ret_select: assert property (@(posedge clk) disable iff (!rst_n)
        (br_code == BR_RET) |-> (src_sel == SRC_RET));
    // R6: map selects the opcode path regardless of the test bit.
    a_r6_map_select: assert property (@(posedge clk) disable iff (!rst_n)
        (br_code == BR_MAP) |-> (src_sel == SRC_MAP));

endmodule

// File: rtl/uaddr_ret_store.sv
// Module: uaddr_ret_store
// Holds subroutine return addresses. DEPTH = 1 gives a single register that
// a pop leaves untouched. DEPTH > 1 gives a circular LIFO that wraps with no
// overflow or underflow detection. Assumes push and pop are never both high.
module uaddr_ret_store #(
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_val,
    output logic [ADDR_W-1:0] top
);

    generate
        if (DEPTH == 1) begin : g_single
            logic [ADDR_W-1:0] ret_q;

            // Capture the return address on a push.
            always_ff @(posedge clk) begin
                if (!rst_n)    ret_q <= '0;
                else if (push) ret_q <= push_val;
            end

            assign top = ret_q;

            // R8: a pop keeps the single stored value.
            a_r8_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
                (pop && !push) |=> (top == $past(top)));
        end else begin : g_stack
            localparam int PW = $clog2(DEPTH);
            localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

            logic [ADDR_W-1:0] mem_q [DEPTH];
            logic [PW-1:0]     ptr_q;
            logic [PW-1:0]     ptr_up;
            logic [PW-1:0]     ptr_dn;

            // Circular neighbours of the pointer.
            always_comb begin
                ptr_up = (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
                ptr_dn = (ptr_q == '0) ? LAST : ptr_q - PW'(1);
            end

            // Move the pointer and write the pushed entry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q <= '0;
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
                end else if (push) begin
                    mem_q[ptr_q] <= push_val;
                    ptr_q        <= ptr_up;
                end else if (pop) begin
                    ptr_q <= ptr_dn;
                end
            end

            assign top = mem_q[ptr_dn];

            // R8: after a push the top of the stack is the pushed value.
            a_r8_push_top: assert property (@(posedge clk) disable iff (!rst_n)
                push |=> (top == $past(push_val)));
        end
    endgenerate

endmodule

// File: rtl/uaddr_src_mux.sv
// Module: uaddr_src_mux
// Four-way next-address multiplexer, with the select encoding from the package.
module uaddr_src_mux
    import uaddr_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [1:0]        src_sel,
    input  logic [ADDR_W-1:0] inc_addr,
    input  logic [ADDR_W-1:0] field_addr,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] map_addr,
    output logic [ADDR_W-1:0] next_addr
);

    // Pick the source of the next control address.
    always_comb begin
        unique case (src_sel)
            SRC_INC:   next_addr = inc_addr;
            SRC_FIELD: next_addr = field_addr;
            SRC_RET:   next_addr = ret_addr;
            default:   next_addr = map_addr;
        endcase
    end

endmodule

// File: rtl/uaddr_sequencer.sv
// Module: uaddr_sequencer (top)
// Control address register with its next-address logic: condition mux,
// input logic, incrementer, opcode mapping, return store and source mux.
// Assumes the microinstruction fields belong to the word addressed by car_addr.
// Needs ADDR_W >= OPC_W + 3, because mapping places a 0, the opcode and two 0s.
module uaddr_sequencer
    import uaddr_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int OPC_W      = 4,
    parameter int RET_DEPTH  = 1,
    parameter int RESET_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cond_sel,
    input  logic [1:0]        br_code,
    input  logic [ADDR_W-1:0] jump_addr,
    input  logic              ind_bit,
    input  logic              acc_sign,
    input  logic              acc_zero,
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] car_addr
);

    localparam int MAP_PAD_HI = ADDR_W - OPC_W - 2;
    localparam logic [ADDR_W-1:0] RST_VAL = ADDR_W'(RESET_ADDR);

    logic              test_bit;
    logic [1:0]        src_sel;
    logic              push;
    logic              pop;
    logic [ADDR_W-1:0] car_q;
    logic [ADDR_W-1:0] inc_addr;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] ret_top;
    logic [ADDR_W-1:0] next_addr;

    uaddr_cond_mux u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_sel (cond_sel),
        .ind_bit  (ind_bit),
        .acc_sign (acc_sign),
        .acc_zero (acc_zero),
        .test_bit (test_bit)
    );

    uaddr_input_logic u_inlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_code  (br_code),
        .test_bit (test_bit),
        .src_sel  (src_sel),
        .push     (push),
        .pop      (pop)
    );

    // Incrementer (wraps at the top) and opcode-to-routine mapping.
    always_comb begin
        inc_addr = car_q + ADDR_W'(1);
        map_addr = {{MAP_PAD_HI{1'b0}}, opcode, 2'b00};
    end

    uaddr_ret_store #(
        .ADDR_W (ADDR_W),
        .DEPTH  (RET_DEPTH)
    ) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (inc_addr),
        .top      (ret_top)
    );

    uaddr_src_mux #(
        .ADDR_W (ADDR_W)
    ) u_mux (
        .src_sel    (src_sel),
        .inc_addr   (inc_addr),
        .field_addr (jump_addr),
        .ret_addr   (ret_top),
        .map_addr   (map_addr),
        .next_addr  (next_addr)
    );

    // Control address register, reset to the fetch routine.
    always_ff @(posedge clk) begin
        if (!rst_n) car_q <= RST_VAL;
        else        car_q <= next_addr;
    end

    assign car_addr = car_q;

    // R1: reset lands on the fetch routine.
    a_r1_reset_addr: assert property (@(posedge clk)
        !rst_n |=> (car_addr == RST_VAL));
    // R3: a taken jump or call loads the target field.
    a_r3_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ((br_code == BR_JUMP || br_code == BR_CALL) && test_bit)
        |=> (car_addr == $past(jump_addr)));
    // R3: a jump or call that is not taken steps by one.
    a_r3_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ((br_code == BR_JUMP || br_code == BR_CALL) && !test_bit)
        |=> (car_addr == ADDR_W'($past(car_addr) + 1)));
    // R4: a taken call leaves the return address on top.
    a_r4_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (br_code == BR_CALL && test_bit)
        |=> (ret_top == ADDR_W'($past(car_addr) + 1)));
    // R5: a return loads the stored address.
    a_r5_return: assert property (@(posedge clk) disable iff (!rst_n)
        (br_code == BR_RET) |=> (car_addr == $past(ret_top)));
    // R6: map loads the opcode routine start.
    a_r6_map: assert property (@(posedge clk) disable iff (!rst_n)
        (br_code == BR_MAP)
        |=> (car_addr == {{MAP_PAD_HI{1'b0}}, $past(opcode), 2'b00}));
    // R7: stepping from the top address wraps to zero.
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_INC && car_addr == '1) |=> (car_addr == '0));

endmodule

// File: tb/test_uaddr_sequencer.sv
// Bench for uaddr_sequencer: one instance with the default single return
// register and one with a four-deep stack, both checked against a model.
module test_uaddr_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cond_sel = '0;
    logic [1:0] br_code = '0;
    logic [6:0] jump_addr = '0;
    logic       ind_bit = 1'b0;
    logic       acc_sign = 1'b0;
    logic       acc_zero = 1'b0;
    logic [3:0] opcode = '0;
    logic [6:0] car_a;
    logic [6:0] car_b;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [6:0] m_car [2];
    logic [6:0] m_stk [2][8];
    int         m_ptr [2];
    int         m_dep [2] = '{1, 4};

    always #(CLK_PERIOD/2) clk = ~clk;

    uaddr_sequencer i_uaddr_sequencer (
        .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .br_code(br_code),
        .jump_addr(jump_addr), .ind_bit(ind_bit), .acc_sign(acc_sign),
        .acc_zero(acc_zero), .opcode(opcode), .car_addr(car_a)
    );

    uaddr_sequencer #(.RET_DEPTH(4)) i_uaddr_sequencer_stk (
        .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .br_code(br_code),
        .jump_addr(jump_addr), .ind_bit(ind_bit), .acc_sign(acc_sign),
        .acc_zero(acc_zero), .opcode(opcode), .car_addr(car_b)
    );

    function automatic logic pick_test(input logic [1:0] c, input logic i,
                                       input logic s, input logic z);
        case (c)
            2'b00:   return 1'b1;
            2'b01:   return i;
            2'b10:   return s;
            default: return z;
        endcase
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: car_addr=%0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_car[k] = 7'd64;
            m_ptr[k] = 0;
            for (int e = 0; e < 8; e++) m_stk[k][e] = '0;
        end
    endtask

    // Called at a falling edge: hold reset for one rising edge and check R1.
    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        check("R1", car_a, m_car[0]);
        check("R1", car_b, m_car[1]);
        rst_n = 1'b1;
    endtask

    // Called at a falling edge: drive one microinstruction, advance, compare.
    task automatic step(input logic [1:0] c, input logic [1:0] b, input logic [6:0] ad,
                        input logic i, input logic s, input logic z,
                        input logic [3:0] op, input string tag);
        logic t;
        cond_sel = c; br_code = b; jump_addr = ad;
        ind_bit = i; acc_sign = s; acc_zero = z; opcode = op;
        t = pick_test(c, i, s, z);
        for (int k = 0; k < 2; k++) begin
            logic [6:0] inc;
            inc = m_car[k] + 7'd1;
            case (b)
                2'b00: m_car[k] = t ? ad : inc;
                2'b01: begin
                    if (t) begin
                        m_stk[k][m_ptr[k]] = inc;
                        m_ptr[k] = (m_ptr[k] + 1) % m_dep[k];
                        m_car[k] = ad;
                    end else begin
                        m_car[k] = inc;
                    end
                end
                2'b10: begin
                    m_car[k] = m_stk[k][(m_ptr[k] + m_dep[k] - 1) % m_dep[k]];
                    m_ptr[k] = (m_ptr[k] + m_dep[k] - 1) % m_dep[k];
                end
                default: m_car[k] = {1'b0, op, 2'b00};
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, car_a, m_car[0]);
        check(tag, car_b, m_car[1]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R2 with R3: each condition selector, both polarities.
        step(2'b00, 2'b00, 7'd10, 0, 0, 0, 4'h0, "R2 R3 always");
        step(2'b01, 2'b00, 7'd50, 0, 1, 1, 4'h0, "R2 R3 ind=0");
        step(2'b01, 2'b00, 7'd50, 1, 0, 0, 4'h0, "R2 R3 ind=1");
        step(2'b10, 2'b00, 7'd90, 1, 0, 1, 4'h0, "R2 R3 sign=0");
        step(2'b10, 2'b00, 7'd90, 0, 1, 0, 4'h0, "R2 R3 sign=1");
        step(2'b11, 2'b00, 7'd20, 1, 1, 0, 4'h0, "R2 R3 zero=0");
        step(2'b11, 2'b00, 7'd20, 0, 0, 1, 4'h0, "R2 R3 zero=1");

        // R4, R5: taken call, untaken call, return ignoring the test bit.
        step(2'b00, 2'b01, 7'd67, 0, 0, 0, 4'h0, "R4 call taken");
        step(2'b01, 2'b01, 7'd5, 0, 0, 0, 4'h0, "R4 call not taken");
        step(2'b01, 2'b10, 7'd0, 0, 0, 0, 4'h0, "R5 return T=0");
        step(2'b00, 2'b10, 7'd0, 0, 0, 0, 4'h0, "R8 second return");

        // R6: map with extreme and mixed opcodes, test bit ignored.
        step(2'b01, 2'b11, 7'd99, 0, 0, 0, 4'hF, "R6 map F");
        step(2'b00, 2'b11, 7'd99, 0, 0, 0, 4'h0, "R6 map 0");
        step(2'b10, 2'b11, 7'd1, 0, 0, 0, 4'h5, "R6 map 5");

        // R7: reach 127, step once, then call from 127 (saves 0).
        step(2'b00, 2'b00, 7'd127, 0, 0, 0, 4'h0, "R7 reach 127");
        step(2'b01, 2'b00, 7'd3, 0, 0, 0, 4'h0, "R7 wrap to 0");
        step(2'b00, 2'b00, 7'd127, 0, 0, 0, 4'h0, "R7 reach 127");
        step(2'b00, 2'b01, 7'd30, 0, 0, 0, 4'h0, "R7 call from 127");
        step(2'b00, 2'b10, 7'd0, 0, 0, 0, 4'h0, "R7 R5 return to 0");

        // R8: nested calls, then unwind (LIFO on the stack instance).
        step(2'b00, 2'b01, 7'd40, 0, 0, 0, 4'h0, "R8 call 1");
        step(2'b00, 2'b01, 7'd70, 0, 0, 0, 4'h0, "R8 call 2");
        step(2'b00, 2'b01, 7'd100, 0, 0, 0, 4'h0, "R8 call 3");
        step(2'b00, 2'b10, 7'd0, 0, 0, 0, 4'h0, "R8 pop 3");
        step(2'b00, 2'b10, 7'd0, 0, 0, 0, 4'h0, "R8 pop 2");
        step(2'b00, 2'b10, 7'd0, 0, 0, 0, 4'h0, "R8 pop 1");

        // R1: reset in mid-run.
        do_reset();

        // Random mix covering R3 to R9.
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] c, b;
            logic [6:0] ad;
            string tg;
            c = 2'($urandom);
            b = 2'($urandom);
            ad = ($urandom % 8 == 0) ? 7'd127 : 7'($urandom);
            case (b)
                2'b00:   tg = "R3 R9 rand jump";
                2'b01:   tg = "R4 R9 rand call";
                2'b10:   tg = "R5 R8 rand return";
                default: tg = "R6 rand map";
            endcase
            step(c, b, ad, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), tg);
            if (n == 1500) do_reset();
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule